// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block pairs a free-running synchronous 16-bit timer with a 16-bit compare register. While one of the four compare modes is selected, the block watches for the timer reaching the compare value. When it does, the block can set an output latch, clear that latch, raise only a compare interrupt flag, or fire a special event. The special event zeroes the timer, which makes the compare value act as a programmable period. It can also request the start of an analog-to-digital conversion.

Software reaches the block through a byte-wide register port. Through it, software writes the compare value, selects the mode, enables the output driver and clears the two interrupt flags. The timer advances only on clocks where the tick enable is high. A converter enable input gates the conversion-start strobe.

Top module: `cet_top`

## Requirements
- R1: After reset the timer, the compare register, the mode field and both flags are zero. The latch, `pin_o` and `conv_start_o` are low. The disable bit is 1, so the control register reads 8'h10 and `pin_oe_o` is low.
- R2: On each clock with `tick_en_i` high, the timer rises by one, wrapping from 16'hFFFF to 0. With `tick_en_i` low it holds, except for a special-event clear.
- R3: A match happens when the mode is 4'b1000 to 4'b1011 and the timer equals the compare value, on the first cycle of that equality only. It sets the compare flag (flags register bit 0) at the same clock edge. A timer stalled on the compare value does not trigger again.
- R4: On a match, mode 4'b1000 sets the output latch to 1 and mode 4'b1001 clears it to 0.
- R5: On a match, mode 4'b1010 sets only the compare flag and leaves the latch unchanged.
- R6: On a match, mode 4'b1011 loads zero into the timer at that edge, so with ticks on every clock the timer counts 0 to C repeatedly, with a period of C+1.
- R7: A mode-4'b1011 match with `adc_en_i` high makes `conv_start_o` high for exactly the following cycle. In other modes, or with `adc_en_i` low, it stays low.
- R8: The overflow flag (flags register bit 1) is set when a tick wraps the timer from 16'hFFFF to 0. A special-event clear at 16'hFFFF does not set it.
- R9: While the mode field is 4'b0000 the latch is held low, so writing mode zero clears it by the second clock edge after the write.
- R10: `pin_o` carries the latch and `pin_oe_o` is the inverse of control bit 4. A 1 in bit 4 releases the pin.
- R11: Writing the flags register clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A set arriving at the same edge wins.
- R12: Any mode other than 4'b1000 to 4'b1011 disables compare: no flag, no latch change, no timer clear, no strobe.
- R13: Register map, all read back:
  - 0: compare low byte.
  - 1: compare high byte.
  - 2: timer low byte (read-only).
  - 3: timer high byte (read-only).
  - 4: control, with the mode in [3:0] and the disable bit in [4].
  - 5: flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| tick_en_i | input | 1 | Timer increment enable |
| adc_en_i | input | 1 | Converter enable, gates conversion start |
| conv_start_o | output | 1 | One-cycle conversion-start strobe |
| cmp_flag_o | output | 1 | Compare interrupt flag |
| ovf_flag_o | output | 1 | Timer overflow flag |
| pin_o | output | 1 | Compare output latch value |
| pin_oe_o | output | 1 | Output driver enable |

## Verification
Every result of a match is registered at the clock edge that sees the timer equal to the compare value: the flag, the latch change, the timer clear and the strobe. All of them become visible together one edge after the timer first shows the compare value. So, after K ticks from zero, the effects of a compare value C appear from K = C+1 onward. The exception is the mode-zero latch clear, which lands one edge after the mode register changes. The bench drives inputs and samples outputs on the falling edge and counts edges from each stimulus. Expected timer, flag, latch and strobe values are computed from K and C in closed form, including K mod (C+1) for the special event.

// File: rtl/cet_pkg.sv
package cet_pkg;
    localparam logic [3:0] MODE_OFF = 4'b0000;
    localparam logic [3:0] MODE_SET = 4'b1000;
    localparam logic [3:0] MODE_CLR = 4'b1001;
    localparam logic [3:0] MODE_SWI = 4'b1010;
    localparam logic [3:0] MODE_SPE = 4'b1011;

    localparam int CTRL_DIS_BIT = 4;
    localparam int FLAG_CMP_BIT = 0;
    localparam int FLAG_OVF_BIT = 1;

    function automatic logic mode_active(input logic [3:0] m);
        return m[3:2] == 2'b10;
    endfunction
endpackage

// File: rtl/cet_timer.sv
module cet_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clr_i,
    output logic [TW-1:0] cnt_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign wrap_o = tick_i && !clr_i && (&s_q.cnt);

    // R2: a tick without a clear advances the count by one
    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
    // R6: a special-event clear leaves zero in the timer
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/cet_match.sv
module cet_match import cet_pkg::*; #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode_i,
    input  logic [TW-1:0] cmp_i,
    input  logic [TW-1:0] cnt_i,
    output logic          hit_o
);
    typedef struct packed {
        logic eq;
    } mt_s;

    mt_s  s_d, s_q;
    logic eq_now;

    always_comb begin
        eq_now = mode_active(mode_i) && (cnt_i == cmp_i);
        s_d    = s_q;
        s_d.eq = eq_now;
        hit_o  = eq_now && !s_q.eq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a match is a single-cycle event
    p_one_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/cet_action.sv
module cet_action import cet_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic [3:0] mode_i,
    input  logic       adc_en_i,
    output logic       latch_o,
    output logic       conv_o,
    output logic       clr_o
);
    typedef struct packed {
        logic latch;
        logic conv;
    } act_s;

    act_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        clr_o    = hit_i && (mode_i == MODE_SPE);
        s_d.conv = clr_o && adc_en_i;
        if (mode_i == MODE_OFF) begin
            s_d.latch = 1'b0;
        end else if (hit_i) begin
            case (mode_i)
                MODE_SET: s_d.latch = 1'b1;
                MODE_CLR: s_d.latch = 1'b0;
                default:  s_d.latch = s_q.latch;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign latch_o = s_q.latch;
    assign conv_o  = s_q.conv;

    // R4: set-high mode raises the latch on a match
    p_set_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && mode_i == MODE_SET) |=> latch_o);
    // R5: interrupt-only mode never moves the latch
    p_swi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && mode_i == MODE_SWI) |=> $stable(latch_o));
    // R9: mode zero holds the latch low
    p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> !latch_o);
    // R7: the strobe only follows an enabled special-event match
    p_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> $past(hit_i && adc_en_i && mode_i == MODE_SPE));
endmodule

// File: rtl/cet_regs.sv
module cet_regs import cet_pkg::*; #(
    parameter int DW = 8,
    parameter int NB = 2,
    parameter int AW = 3,
    localparam int TW = DW * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [TW-1:0] cnt_i,
    input  logic          set_cf_i,
    input  logic          set_of_i,
    output logic [TW-1:0] cmp_o,
    output logic [3:0]    mode_o,
    output logic          dis_o,
    output logic          cf_o,
    output logic          of_o,
    output logic [DW-1:0] rdata_o
);
    localparam logic [AW-1:0] CTRL_A = AW'(2 * NB);
    localparam logic [AW-1:0] FLAG_A = AW'(2 * NB + 1);

    typedef struct packed {
        logic [TW-1:0] cmp;
        logic [3:0]    mode;
        logic          dis;
        logic          cf;
        logic          of;
    } reg_s;

    reg_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NB; i++) begin
            if (wr_i && addr_i == AW'(i)) s_d.cmp[i*DW +: DW] = wdata_i;
        end
        if (wr_i && addr_i == CTRL_A) begin
            s_d.mode = wdata_i[3:0];
            s_d.dis  = wdata_i[CTRL_DIS_BIT];
        end
        if (wr_i && addr_i == FLAG_A) begin
            s_d.cf = s_q.cf & wdata_i[FLAG_CMP_BIT];
            s_d.of = s_q.of & wdata_i[FLAG_OVF_BIT];
        end
        if (set_cf_i) s_d.cf = 1'b1;
        if (set_of_i) s_d.of = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.dis <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr_i == AW'(i))      rdata_o = s_q.cmp[i*DW +: DW];
            if (addr_i == AW'(NB + i)) rdata_o = cnt_i[i*DW +: DW];
        end
        if (addr_i == CTRL_A) begin
            rdata_o[3:0]         = s_q.mode;
            rdata_o[CTRL_DIS_BIT] = s_q.dis;
        end
        if (addr_i == FLAG_A) begin
            rdata_o[FLAG_CMP_BIT] = s_q.cf;
            rdata_o[FLAG_OVF_BIT] = s_q.of;
        end
    end

    assign cmp_o  = s_q.cmp;
    assign mode_o = s_q.mode;
    assign dis_o  = s_q.dis;
    assign cf_o   = s_q.cf;
    assign of_o   = s_q.of;

    // R11: a zero written to the compare flag clears it unless a set coincides
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == FLAG_A && !wdata_i[FLAG_CMP_BIT] && !set_cf_i) |=> !cf_o);
    // R13: the compare value changes only through its own addresses
    p_cmp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i < AW'(NB)) |=> $stable(cmp_o));
endmodule

// File: rtl/cet_top.sv
module cet_top import cet_pkg::*; #(
    parameter int DW = 8,
    parameter int NB = 2,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    input  logic          tick_en_i,
    input  logic          adc_en_i,
    output logic          conv_start_o,
    output logic          cmp_flag_o,
    output logic          ovf_flag_o,
    output logic          pin_o,
    output logic          pin_oe_o
);
    localparam int TW = DW * NB;

    logic [TW-1:0] cnt_w, cmp_w;
    logic [3:0]    mode_w;
    logic          dis_w, hit_w, clr_w, wrap_w, latch_w;

    cet_regs #(.DW(DW), .NB(NB), .AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .cnt_i(cnt_w), .set_cf_i(hit_w), .set_of_i(wrap_w),
        .cmp_o(cmp_w), .mode_o(mode_w), .dis_o(dis_w), .cf_o(cmp_flag_o),
        .of_o(ovf_flag_o), .rdata_o(reg_rdata_o)
    );

    cet_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en_i), .clr_i(clr_w),
        .cnt_o(cnt_w), .wrap_o(wrap_w)
    );

    cet_match #(.TW(TW)) i_match (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_w), .cmp_i(cmp_w),
        .cnt_i(cnt_w), .hit_o(hit_w)
    );

    cet_action i_action (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_w), .mode_i(mode_w),
        .adc_en_i(adc_en_i), .latch_o(latch_w), .conv_o(conv_start_o), .clr_o(clr_w)
    );

    assign pin_o    = latch_w;
    assign pin_oe_o = !dis_w;

    // R3: every match leaves the compare flag set
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |=> cmp_flag_o);
    // R8: a special-event clear never raises the overflow flag
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !ovf_flag_o) |=> !ovf_flag_o);
endmodule

// File: tb/test_cet_top.sv
module test_cet_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       tick_en_i = 1'b0;
    logic       adc_en_i = 1'b0;
    logic       conv_start_o, cmp_flag_o, ovf_flag_o, pin_o, pin_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cet_top i_cet_top (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tick_en_i(tick_en_i),
        .adc_en_i(adc_en_i), .conv_start_o(conv_start_o), .cmp_flag_o(cmp_flag_o),
        .ovf_flag_o(ovf_flag_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic rd_timer(output logic [15:0] t);
        logic [7:0] lo, hi;
        rd(3'd2, lo);
        rd(3'd3, hi);
        t = {hi, lo};
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_en_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] t;
        @(negedge clk);
        do_reset();

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1 reg", {24'd0, d}, (a == 4) ? 32'h10 : 32'h0);
        end
        check("R1 pin_oe", pin_oe_o, 0);
        check("R1 pin", pin_o, 0);
        check("R1 conv", conv_start_o, 0);
        check("R1 flags", {cmp_flag_o, ovf_flag_o}, 0);

        // R13: readback
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd4, 8'h1A);
        rd(3'd0, d); check("R13 cmp lo", d, 8'hA5);
        rd(3'd1, d); check("R13 cmp hi", d, 8'h3C);
        rd(3'd4, d); check("R13 ctrl", d, 8'h1A);
        rd_timer(t); check("R13 timer", t, 0);

        // Sweep over all 16 modes and several compare values
        for (int m = 0; m < 16; m++) begin
            for (int ci = 0; ci < 3; ci++) begin
                int c, per;
                logic adc, dis, act, spe;
                string tg;
                c   = (ci == 0) ? 2 : (ci == 1) ? 5 : 9;
                per = c + 1;
                adc = 1'((m + ci) % 2);
                dis = (ci == 1);
                act = (m >= 8 && m <= 11);
                spe = (m == 11);
                tg  = act ? "R3" : "R12";
                do_reset();
                adc_en_i = adc;
                wr(3'd0, 8'(c));
                wr(3'd1, 8'h00);
                wr(3'd4, 8'(m) | (dis ? 8'h10 : 8'h00));
                check("R10 oe", pin_oe_o, !dis);
                tick_en_i = 1'b1;
                for (int k = 1; k <= 2 * c + 4; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    rd_timer(t);
                    check(spe ? "R6 timer" : "R2 timer", t, spe ? (k % per) : k);
                    check({tg, " flag"}, cmp_flag_o, act && (k >= per));
                    check((m == 8) ? "R4 latch" : (m == 10) ? "R5 latch" : "R12 latch",
                          pin_o, (m == 8) && (k >= per));
                    check("R7 conv", conv_start_o, spe && adc && (k % per == 0));
                end
                tick_en_i = 1'b0;
            end
        end

        // R4 + R9: set latch, then mode zero forces it low
        do_reset();
        wr(3'd0, 8'd3); wr(3'd4, 8'h08);
        tick_en_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        tick_en_i = 1'b0;
        check("R4 set", pin_o, 1);
        wr(3'd4, 8'h00);
        @(negedge clk);
        check("R9 mode0 low", pin_o, 0);

        // R4: clear-low mode
        do_reset();
        wr(3'd0, 8'd3); wr(3'd4, 8'h08);
        tick_en_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        tick_en_i = 1'b0;
        wr(3'd0, 8'd8); wr(3'd4, 8'h09);
        tick_en_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R4 before clear", pin_o, 1);
        @(negedge clk);
        tick_en_i = 1'b0;
        rd_timer(t); check("R2 timer", t, 9);
        check("R4 cleared", pin_o, 0);

        // R3 stall, R5, R11
        do_reset();
        wr(3'd0, 8'd4); wr(3'd4, 8'h0A);
        tick_en_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        tick_en_i = 1'b0;
        check("R3 not yet", cmp_flag_o, 0);
        @(negedge clk);
        check("R3 flag", cmp_flag_o, 1);
        check("R5 latch", pin_o, 0);
        wr(3'd5, 8'h01);
        check("R11 keep", cmp_flag_o, 1);
        wr(3'd5, 8'h02);
        check("R11 clear", cmp_flag_o, 0);
        repeat (5) @(negedge clk);
        check("R3 no retrigger", cmp_flag_o, 0);
        rd_timer(t); check("R2 hold", t, 4);

        // R8: natural wrap
        do_reset();
        tick_en_i = 1'b1;
        repeat (65535) @(posedge clk);
        @(negedge clk);
        rd_timer(t); check("R2 max", t, 16'hFFFF);
        check("R8 before wrap", ovf_flag_o, 0);
        @(negedge clk);
        tick_en_i = 1'b0;
        rd_timer(t); check("R2 wrap", t, 0);
        check("R8 wrap", ovf_flag_o, 1);
        check("R12 no cmp", cmp_flag_o, 0);
        wr(3'd5, 8'h01);
        check("R11 ovf clear", ovf_flag_o, 0);

        // R8: special-event clear at the top value
        do_reset();
        adc_en_i = 1'b1;
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd4, 8'h0B);
        tick_en_i = 1'b1;
        repeat (65535) @(posedge clk);
        @(negedge clk);
        rd_timer(t); check("R6 at top", t, 16'hFFFF);
        @(negedge clk);
        tick_en_i = 1'b0;
        rd_timer(t); check("R6 cleared", t, 0);
        check("R8 no ovf", ovf_flag_o, 0);
        check("R3 flag", cmp_flag_o, 1);
        check("R7 conv", conv_start_o, 1);
        @(negedge clk);
        check("R7 one cycle", conv_start_o, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule